// File: doc/BRIEF.md
# Latency-Configurable Memory Model

A single-clock storage array with one write port and one read port. The number of cycles a read takes and the number of cycles before a write reaches the array are set by two independent parameters. A third parameter picks how a read treats a word that a write is changing at the same time. One module can therefore stand in for any latency combination a memory generator might produce, so the surrounding logic sees the timing it will meet in silicon.

The write port takes an enable, an address, a data word and a single mask bit. A write lands only when both the enable and the mask are high. Writes travel through a delay line before they reach the array. Reads travel through either an address line or a data line, depending on the collision policy. With the default parameters the array holds 256 words of 32 bits, selected by an 8-bit address. Parameters outside the legal range stop elaboration.

Top module: `lat_mem`

## Requirements
- R1: For a read presented with `rdEn` high in cycle t, `rdData` carries the result during cycle t+RD_LAT. With RD_LAT = 0 the output is combinational from `rdAddr`.
- R2: A write accepted in cycle t (`wrEn` and `wrMask` both 1) is seen by the array from cycle t+WR_LAT onward. Before that cycle the array holds the earlier contents of the word.
- R3: With WRITE_FIRST = 0 (read-first), a read returns the word as the array held it in the cycle the read was presented.
- R4: With WRITE_FIRST = 1 (write-first) and RD_LAT of at least 1, a read returns the word as the array holds it in the cycle the result appears on `rdData`.
- R5: A write presented with `wrEn` = 1 and `wrMask` = 0 leaves the addressed word unchanged.
- R6: When one address is written twice, later reads of it return the data of the later write.
- R7: While `rdEn` stays low (RD_LAT of at least 1), the read pipeline takes in nothing new. Read-first keeps showing the last result. Write-first keeps showing the current word at the last read address.
- R8: `rst` is synchronous and active high. Writes presented while it is high are dropped, and so is any accepted write that has not reached the array by the clock edge at which `rst` is sampled high. Array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the write pipeline, active high |
| wrEn | input | 1 | Write request |
| wrAddr | input | AW | Write address (8 by default) |
| wrData | input | DW | Write data (32 by default) |
| wrMask | input | 1 | Write mask; 0 suppresses the write |
| rdEn | input | 1 | Read request |
| rdAddr | input | AW | Read address |
| rdData | output | DW | Read result, RD_LAT cycles after the request |

## Verification
A write valid bit that is lost or duplicated in the pipeline shows up as a stale or wrong word on the first read of that address after the write's commit cycle, which is WR_LAT cycles after it was issued. A misaligned stage in the read line gives a result one cycle early or late, so the next read check or hold check sees the neighbouring word at once. The policy setting only shows when a read overlaps a write in flight, so dense random traffic on sixteen addresses is driven into three differently configured copies. A reset that failed to flush the write pipeline would only show on a later read of the flushed address.

// File: rtl/lat_mem_pkg.sv
package lat_mem_pkg;

  // Strobes the control side hands to the datapath every cycle.
  typedef struct packed {
    logic arrayWrite;  // commit the word at the tail of the write line
    logic rdCapture;   // load the head of the read line
  } memStrobes_t;

endpackage

// File: rtl/lat_mem_ctrl.sv
module lat_mem_ctrl
  import lat_mem_pkg::*;
#(
  parameter int WR_LAT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        wrMask,
  input  logic        rdEn,
  output memStrobes_t strobes
);

  logic arrWr;

  generate
    if (WR_LAT == 1) begin : g_wr_direct
      assign arrWr = wrEn & wrMask & ~rst;

      // R5: a masked write never reaches the array
      a_r5_mask_blocks_commit: assert property (@(posedge clk) disable iff (rst)
        (wrEn && !wrMask) |-> !strobes.arrayWrite);
    end else begin : g_wr_piped
      logic [WR_LAT-1:1] wvq;

      always_ff @(posedge clk) begin
        if (rst) begin
          wvq <= '0;
        end else begin
          wvq[1] <= wrEn & wrMask;
          for (int j = 2; j < WR_LAT; j++) begin
            wvq[j] <= wvq[j-1];
          end
        end
      end

      assign arrWr = wvq[WR_LAT-1] & ~rst;

      // R5: a masked write enters no valid slot
      a_r5_mask_no_slot: assert property (@(posedge clk) disable iff (rst)
        (wrEn && !wrMask) |=> !wvq[1]);

      // R8: leaving reset the write line is empty
      a_r8_reset_flush: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (wvq == '0));

      // R2: nothing commits unless a write was accepted earlier
      a_r2_no_spurious_commit: assert property (@(posedge clk) disable iff (rst)
        ((wvq == '0) && !(wrEn && wrMask)) |=> !strobes.arrayWrite);
    end
  endgenerate

  always_comb begin
    strobes.arrayWrite = arrWr;
    strobes.rdCapture  = rdEn;
  end

endmodule

// File: rtl/lat_mem_dp.sv
module lat_mem_dp
  import lat_mem_pkg::*;
#(
  parameter int DW          = 32,
  parameter int DEPTH       = 256,
  parameter int AW          = 8,
  parameter int RD_LAT      = 2,
  parameter int WR_LAT      = 2,
  parameter bit WRITE_FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  memStrobes_t   strobes,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] commitAddr;
  logic [DW-1:0] commitData;

  // Write line: address and data shift every cycle; the valid bit
  // travelling in the control decides whether the tail commits.
  generate
    if (WR_LAT == 1) begin : g_wline_none
      assign commitAddr = wrAddr;
      assign commitData = wrData;
    end else begin : g_wline
      logic [AW-1:0] wAddrQ [1:WR_LAT-1];
      logic [DW-1:0] wDataQ [1:WR_LAT-1];

      always_ff @(posedge clk) begin
        wAddrQ[1] <= wrAddr;
        wDataQ[1] <= wrData;
        for (int j = 2; j < WR_LAT; j++) begin
          wAddrQ[j] <= wAddrQ[j-1];
          wDataQ[j] <= wDataQ[j-1];
        end
      end

      assign commitAddr = wAddrQ[WR_LAT-1];
      assign commitData = wDataQ[WR_LAT-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.arrayWrite) mem[commitAddr] <= commitData;
  end

  // Read line: the head loads only on a request, later stages copy the
  // one before, so after the last request every stage holds one value.
  generate
    if (RD_LAT == 0) begin : g_rd_comb
      assign rdData = mem[rdAddr];
    end else begin : g_rd_piped
      localparam int CW = $clog2(RD_LAT + 1) + 1;
      logic [CW-1:0] idleCnt;

      always_ff @(posedge clk) begin
        if (rst || strobes.rdCapture) idleCnt <= '0;
        else if (idleCnt != CW'(RD_LAT)) idleCnt <= idleCnt + 1'b1;
      end

      if (WRITE_FIRST) begin : g_addr_line
        logic [AW-1:0] aPipe [1:RD_LAT];

        always_ff @(posedge clk) begin
          if (strobes.rdCapture) aPipe[1] <= rdAddr;
          for (int j = 2; j <= RD_LAT; j++) begin
            aPipe[j] <= aPipe[j-1];
          end
        end

        assign rdData = mem[aPipe[RD_LAT]];

        // R7: with no request the address at the tail stays put
        a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
          (idleCnt == CW'(RD_LAT) && !strobes.rdCapture) |=> $stable(aPipe[RD_LAT]));
      end else begin : g_data_line
        logic [DW-1:0] dPipe [1:RD_LAT];

        always_ff @(posedge clk) begin
          if (strobes.rdCapture) dPipe[1] <= mem[rdAddr];
          for (int j = 2; j <= RD_LAT; j++) begin
            dPipe[j] <= dPipe[j-1];
          end
        end

        assign rdData = dPipe[RD_LAT];

        // R7: with no request the read-first output holds
        a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
          (idleCnt == CW'(RD_LAT) && !strobes.rdCapture) |=> $stable(rdData));
      end
    end
  endgenerate

endmodule

// File: rtl/lat_mem.sv
module lat_mem
  import lat_mem_pkg::*;
#(
  parameter int DW          = 32,
  parameter int DEPTH       = 256,
  parameter int RD_LAT      = 2,
  parameter int WR_LAT      = 2,
  parameter bit WRITE_FIRST = 1'b0,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          wrMask,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);

  generate
    if (RD_LAT < 0 || WR_LAT < 1) begin : g_bad_params
      $error("lat_mem: RD_LAT must be >= 0 and WR_LAT >= 1");
    end
  endgenerate

  memStrobes_t strobes;

  lat_mem_ctrl #(
    .WR_LAT (WR_LAT)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrMask  (wrMask),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  lat_mem_dp #(
    .DW          (DW),
    .DEPTH       (DEPTH),
    .AW          (AW),
    .RD_LAT      (RD_LAT),
    .WR_LAT      (WR_LAT),
    .WRITE_FIRST (WRITE_FIRST)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData)
  );

endmodule

// File: tb/sim_lat_mem.sv
`timescale 1ns/1ps
module sim_lat_mem;

  localparam int NL = 3;
  localparam int RLv [NL] = '{2, 1, 0};
  localparam int WLv [NL] = '{2, 3, 1};
  localparam bit WFv [NL] = '{1'b0, 1'b1, 1'b0};

  typedef struct {
    int          due;
    logic [7:0]  addr;
    logic [31:0] val;
    int          phase;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, wrMask = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdq [NL];

  always #5 clk = ~clk;

  lat_mem u0 (.clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
              .wrMask(wrMask), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdq[0]));

  lat_mem #(.RD_LAT(RLv[1]), .WR_LAT(WLv[1]), .WRITE_FIRST(WFv[1])) u1 (
              .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
              .wrMask(wrMask), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdq[1]));

  lat_mem #(.RD_LAT(RLv[2]), .WR_LAT(WLv[2]), .WRITE_FIRST(WFv[2])) u2 (
              .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
              .wrMask(wrMask), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdq[2]));

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          phase = 0;
  bit          done = 1'b0;
  logic [31:0] shadow [NL][256];
  item_t       sbq  [NL][$];
  item_t       pend [NL][$];
  bit          haveLast [NL];
  logic [7:0]  lastAddr [NL];
  logic [31:0] lastVal  [NL];
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  function automatic string phaseTag(int p);
    case (p)
      1: return "R2 init";
      2: return "R6 rewrite";
      3: return "R5 masked";
      4: return "R8 reset";
      default: return "R2 traffic";
    endcase
  endfunction

  function automatic string laneTag(int l);
    if (RLv[l] == 0) return "R1";
    if (WFv[l]) return "R1 R4";
    return "R1 R3";
  endfunction

  task automatic check(int l, logic [31:0] got, logic [31:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s lane %0d cycle %0d: actual %h expected %h", tag, l, cyc, got, exp);
    end
  endtask

  // Driver: one cycle of stimulus, pushes expectations into the queues.
  task automatic step(bit r, bit we, logic [7:0] wa, logic [31:0] wd, bit wm,
                      bit re, logic [7:0] ra);
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      while (pend[l].size() > 0 && pend[l][0].due <= cyc) begin
        shadow[l][pend[l][0].addr] = pend[l][0].val;
        void'(pend[l].pop_front());
      end
      if (r) pend[l].delete();
    end
    rst = r; wrEn = we; wrAddr = wa; wrData = wd; wrMask = wm;
    rdEn = re; rdAddr = ra;
    for (int l = 0; l < NL; l++) begin
      if (re && !r) begin
        item_t it;
        it.due = cyc + RLv[l]; it.addr = ra; it.val = shadow[l][ra]; it.phase = phase;
        sbq[l].push_back(it);
      end
      if (we && wm && !r) begin
        item_t pw;
        pw.due = cyc + WLv[l]; pw.addr = wa; pw.val = wd; pw.phase = phase;
        pend[l].push_back(pw);
      end
    end
    #1;
    monitor();
    cyc++;
  endtask

  // Monitor: pops due results, otherwise checks the hold behaviour.
  task automatic monitor();
    for (int l = 0; l < NL; l++) begin
      if (sbq[l].size() > 0 && sbq[l][0].due == cyc) begin
        item_t it;
        logic [31:0] exp;
        it = sbq[l].pop_front();
        exp = (WFv[l] && RLv[l] > 0) ? shadow[l][it.addr] : it.val;
        check(l, rdq[l], exp, {laneTag(l), " ", phaseTag(it.phase)});
        haveLast[l] = 1'b1; lastAddr[l] = it.addr; lastVal[l] = exp;
      end else if (haveLast[l] && RLv[l] > 0) begin
        check(l, rdq[l], WFv[l] ? shadow[l][lastAddr[l]] : lastVal[l], "R7 hold");
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 1'b0, rdAddr);
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  initial begin
    for (int l = 0; l < NL; l++) begin
      haveLast[l] = 1'b0;
      for (int a = 0; a < 256; a++) shadow[l][a] = '0;
    end
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h0, 32'h0, 1'b0, 1'b0, 8'h0);

    phase = 1;
    for (int a = 0; a < 16; a++) step(1'b0, 1'b1, 8'(a), 32'hC300_1000 + a, 1'b1, 1'b0, 8'h0);
    idle(4);
    for (int a = 0; a < 16; a++) step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 8'(a));
    idle(4);
    // read two cycles after a write, and a read colliding with a write
    step(1'b0, 1'b1, 8'd5, 32'h5555_0001, 1'b1, 1'b0, 8'h0);
    idle(1);
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 8'd5);
    step(1'b0, 1'b1, 8'd5, 32'h5555_0002, 1'b1, 1'b1, 8'd5);
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 8'd5);
    idle(4);

    phase = 2;
    step(1'b0, 1'b1, 8'd7, 32'h7777_000A, 1'b1, 1'b0, 8'h0);
    step(1'b0, 1'b1, 8'd7, 32'h7777_000B, 1'b1, 1'b0, 8'h0);
    idle(4);
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 8'd7);
    idle(4);

    phase = 3;
    step(1'b0, 1'b1, 8'd9, 32'hDEAD_BEEF, 1'b0, 1'b0, 8'h0);
    idle(4);
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 8'd9);
    idle(4);

    phase = 4;
    step(1'b0, 1'b1, 8'd3, 32'h3333_0003, 1'b1, 1'b0, 8'h0);
    step(1'b1, 1'b1, 8'd4, 32'h4444_0004, 1'b1, 1'b0, 8'h0);
    step(1'b1, 1'b1, 8'd4, 32'h4444_0005, 1'b1, 1'b0, 8'h0);
    idle(4);
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 8'd3);
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 8'd4);
    idle(4);

    phase = 5;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r0, r1;
      r0 = nextRand();
      r1 = nextRand();
      step(1'b0, r0[0], {4'h0, r0[7:4]}, r1, (r0[2:1] != 2'b00), r0[8], {4'h0, r0[15:12]});
    end
    idle(6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule